// File: doc/BRIEF.md
# Wake-up request detector

This block watches a small set of asynchronous wake-up pins and turns activity on them into request lines that a power controller can use to leave a low-power standby state. Every channel carries its own trigger setting (active-low level, active-high level, falling edge, rising edge, or any edge) and its own enable bit. In the any-edge setting the channel also keeps a small status field that tells software which edge direction or directions produced the request.

Software programs each channel through a simple write port with an address that selects the channel, and reads the settings and status back through a combinational read port. A per-channel clear strobe drops a latched edge request and wipes the status field. The trigger setting has to be chosen before the enable is set. When a single write tries to do both, the block applies the new setting and leaves the enable as it was.

Top module: `wake_req_detect`

## Requirements
- R1: Mode code 000 requests while the synchronized pin is low and code 001 while it is high, for as long as the channel is enabled. A clear strobe has no effect on a level request.
- R2: Mode codes 010 (falling), 011 (rising) and 100 (either edge) latch a request on the matching edge. The request holds through later pin activity until the clear strobe.
- R3: A channel holding one of the reserved mode codes 101, 110 or 111 never raises its request, whatever the pin does.
- R4: In mode 100 the status field gathers the edges seen: bit 0 is set by a rising edge and bit 1 by a falling edge, so 01 means rising, 10 falling and 11 both. In every other mode the status reads 00.
- R5: While the enable bit is 0 the request is low and the status field keeps its value.
- R6: The clear strobe zeroes the status field and drops a latched edge request one cycle later. When a clear and an edge land in the same cycle, the clear wins.
- R7: A write that changes the mode applies the new mode, zeroes the status and the pending request, and cannot set the enable: the enable keeps its old value, or becomes 0 if the write's enable bit is 0. A write that leaves the mode unchanged loads the enable bit.
- R8: Register layout per channel: bit 0 is the enable, bits 3:1 the mode, bits 5:4 the status (read-only), and bits 7:6 read as 0. Writes to bits 7:4 have no effect.
- R9: Each pin passes through two synchronizing flops. A level request follows a pin change after two rising clock edges, and an edge request appears after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous wake-up pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Channel selected by a write |
| wr_data | input | 8 | Write data, laid out as in R8 |
| rd_addr | input | ADDR_W | Channel selected for reading |
| rd_data | output | 8 | Read data of the selected channel |
| clr_i | input | NCH | Per-channel clear strobe |
| req_o | output | NCH | Per-channel wake-up request |

## Verification
The bench checks that a rise followed by a fall in any-edge mode leaves status 11. A design that overwrote the status instead of merging into it would show only the last edge. It issues the combined mode-and-enable write and checks that the enable does not come up, because a design that honoured it would start detecting with a stale or half-applied mode. Reserved mode codes are driven with full pin swings, and a faulty decoder would let them fall into one of the edge or level cases. The bench also counts the exact clock edges of synchronizer latency, which catches a missing or extra flop stage.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  localparam int MODE_W   = 3;
  localparam int STAT_W   = 2;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 0;
  localparam int MODE_LSB = 1;
  localparam int STAT_LSB = 4;

  localparam logic [MODE_W-1:0] MD_LOW  = 3'd0;
  localparam logic [MODE_W-1:0] MD_HIGH = 3'd1;
  localparam logic [MODE_W-1:0] MD_FALL = 3'd2;
  localparam logic [MODE_W-1:0] MD_RISE = 3'd3;
  localparam logic [MODE_W-1:0] MD_BOTH = 3'd4;

  // true for the three latched trigger codes
  function automatic logic is_edge(input logic [MODE_W-1:0] m);
    return (m == MD_FALL) || (m == MD_RISE) || (m == MD_BOTH);
  endfunction

  // does an edge event match the programmed edge kind
  function automatic logic edge_hit(input logic [MODE_W-1:0] m,
                                    input logic r, input logic f);
    case (m)
      MD_FALL: return f;
      MD_RISE: return r;
      MD_BOTH: return r | f;
      default: return 1'b0;
    endcase
  endfunction

  // does the current pin level match the programmed level kind
  function automatic logic level_hit(input logic [MODE_W-1:0] m, input logic s);
    case (m)
      MD_LOW:  return ~s;
      MD_HIGH: return s;
      default: return 1'b0;
    endcase
  endfunction

  // merge newly seen edges into the recorded ones: bit0 rise, bit1 fall
  function automatic logic [STAT_W-1:0] stat_merge(input logic [STAT_W-1:0] old,
                                                   input logic r, input logic f);
    return old | {f, r};
  endfunction
endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin,
  output logic [NCH-1:0] lvl,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin[c];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl[c]  = sync_q;
    assign rise[c] = sync_q & ~prev_q;
    assign fall[c] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/wkd_regs.sv
module wkd_regs
  import wkd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [MODE_LSB+MODE_W-1:0]   wr_low,
  output logic [NCH-1:0]               en,
  output logic [NCH-1:0][MODE_W-1:0]   mode,
  output logic [NCH-1:0]               mode_chg
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [MODE_W-1:0] new_mode;
    logic              en_q;
    logic [MODE_W-1:0] mode_q;

    assign hit         = wr_en && (wr_addr == ADDR_W'(c));
    assign new_mode    = wr_low[MODE_LSB +: MODE_W];
    assign mode_chg[c] = hit && (new_mode != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        mode_q <= MD_LOW;
      end else if (hit) begin
        mode_q <= new_mode;
        // a mode-changing write may drop the enable but never raise it
        if (mode_chg[c]) en_q <= en_q & wr_low[EN_BIT];
        else             en_q <= wr_low[EN_BIT];
      end
    end

    assign en[c]   = en_q;
    assign mode[c] = mode_q;
  end
endmodule

// File: rtl/wkd_chan.sv
module wkd_chan
  import wkd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              mode_chg,
  input  logic              clr,
  input  logic              lvl,
  input  logic              rise,
  input  logic              fall,
  output logic              req,
  output logic [STAT_W-1:0] stat,
  output logic              edge_ev
);
  logic              pend_q;
  logic [STAT_W-1:0] stat_q;

  assign edge_ev = en && edge_hit(mode, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pend_q <= 1'b0;
    else if (clr || mode_chg || !en || !is_edge(mode)) pend_q <= 1'b0;
    else if (edge_ev)                             pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   stat_q <= '0;
    else if (clr || mode_chg || mode != MD_BOTH)  stat_q <= '0;
    else if (en)                                  stat_q <= stat_merge(stat_q, rise, fall);
  end

  assign req  = en && (is_edge(mode) ? pend_q : level_hit(mode, lvl));
  assign stat = stat_q;
endmodule

// File: rtl/wake_req_detect.sv
module wake_req_detect
  import wkd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NCH-1:0]    clr_i,
  output logic [NCH-1:0]    req_o
);
  localparam int LOW_W = MODE_LSB + MODE_W;

  logic [NCH-1:0]             lvl_w, rise_w, fall_w;
  logic [NCH-1:0]             en_w, mode_chg_w, edge_ev_w;
  logic [NCH-1:0][MODE_W-1:0] mode_w;
  logic [NCH-1:0][STAT_W-1:0] stat_w;
  logic                       unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:LOW_W];

  wkd_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_i),
    .lvl(lvl_w), .rise(rise_w), .fall(fall_w)
  );

  wkd_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_low(wr_data[LOW_W-1:0]),
    .en(en_w), .mode(mode_w), .mode_chg(mode_chg_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wkd_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .en(en_w[c]), .mode(mode_w[c]), .mode_chg(mode_chg_w[c]),
      .clr(clr_i[c]), .lvl(lvl_w[c]), .rise(rise_w[c]), .fall(fall_w[c]),
      .req(req_o[c]), .stat(stat_w[c]), .edge_ev(edge_ev_w[c])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data[EN_BIT]                 = en_w[i];
        rd_data[MODE_LSB +: MODE_W]     = mode_w[i];
        rd_data[STAT_LSB +: STAT_W]     = stat_w[i];
      end
    end
  end
endmodule

// File: rtl/wkd_chk.sv
module wkd_chk
  import wkd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic                       wr_en_bit,
  input logic [NCH-1:0]             en,
  input logic [NCH-1:0][MODE_W-1:0] mode,
  input logic [NCH-1:0]             mode_chg,
  input logic [NCH-1:0]             clr,
  input logic [NCH-1:0]             rise,
  input logic [NCH-1:0][STAT_W-1:0] stat,
  input logic [NCH-1:0]             req
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R3
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[c] > MD_BOTH) |-> !req[c]);
    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |-> !req[c]);
    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[c] && !clr[c] && !mode_chg[c]) |=> $stable(stat[c]));
    // R4
    stat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[c] != '0) |-> (mode[c] == MD_BOTH));
    // R4
    rise_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && mode[c] == MD_BOTH && rise[c] && !clr[c] && !mode_chg[c]) |=> stat[c][0]);
    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && !mode_chg[c] && is_edge(mode[c])) |=> (!req[c] && stat[c] == '0));
    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[c] && is_edge(mode[c]) && !clr[c] && !wr_en) |=> req[c]);
    // R7
    combined_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(c) && wr_en_bit && mode_chg[c] && !en[c]) |=> !en[c]);
  end
endmodule

bind wake_req_detect wkd_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_en_bit(wr_data[0]), .en(en_w), .mode(mode_w), .mode_chg(mode_chg_w),
  .clr(clr_i), .rise(rise_w), .stat(stat_w), .req(req_o)
);

// File: tb/wake_req_detect_tb.sv
module wake_req_detect_tb;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_i = '0;
  logic           wr_en = 1'b0;
  logic [0:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [0:0]     rd_addr = '0;
  logic [7:0]     rd_data;
  logic [NCH-1:0] clr_i = '0;
  logic [NCH-1:0] req_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench view of the block
  logic       m_en   [NCH];
  logic [2:0] m_mode [NCH];
  logic       m_pend [NCH];
  logic [1:0] m_stat [NCH];

  always #10 clk = ~clk;

  wake_req_detect #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clr_i(clr_i), .req_o(req_o)
  );

  function automatic logic exp_req(input int c);
    if (!m_en[c]) return 1'b0;
    case (m_mode[c])
      3'd0: return !pin_i[c];
      3'd1: return pin_i[c];
      3'd2, 3'd3, 3'd4: return m_pend[c];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int c);
    return {2'b00, m_stat[c], m_mode[c], m_en[c]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(tag, {7'd0, req_o[c]}, {7'd0, exp_req(c)});
      rd_addr = 1'(c);
      #1;
      chk(tag, rd_data, exp_rd(c));
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input int c, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'(c); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (d[3:1] != m_mode[c]) begin
      m_mode[c] = d[3:1];
      m_en[c]   = m_en[c] & d[0];
      m_pend[c] = 1'b0;
      m_stat[c] = 2'b00;
    end else begin
      m_en[c] = d[0];
    end
    if (!m_en[c]) m_pend[c] = 1'b0;
    settle();
    check_all(tag);
  endtask

  task automatic drive_pin(input int c, input logic v, input string tag);
    logic r, f;
    r = v & !pin_i[c];
    f = !v & pin_i[c];
    @(negedge clk);
    pin_i[c] = v;
    if (m_en[c]) begin
      case (m_mode[c])
        3'd2: if (f) m_pend[c] = 1'b1;
        3'd3: if (r) m_pend[c] = 1'b1;
        3'd4: begin
          if (r | f) m_pend[c] = 1'b1;
          m_stat[c] = m_stat[c] | {f, r};
        end
        default: ;
      endcase
    end
    settle();
    check_all(tag);
  endtask

  task automatic do_clear(input int c, input string tag);
    @(negedge clk);
    clr_i[c] = 1'b1;
    @(negedge clk);
    clr_i[c] = 1'b0;
    m_pend[c] = 1'b0;
    m_stat[c] = 2'b00;
    settle();
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_mode[c] = 0; m_pend[c] = 0; m_stat[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R8 reset");

    // R1 level modes
    do_write(0, 8'h00, "R1");
    do_write(0, 8'h01, "R1 low en");
    drive_pin(0, 1'b1, "R1 low released");
    drive_pin(0, 1'b0, "R1 low active");
    do_clear(0, "R1 clear ignored in level");
    do_write(1, 8'h02, "R1");
    do_write(1, 8'h03, "R1 high en");
    drive_pin(1, 1'b1, "R1 high active");

    // R9 latency: rising edge mode on ch0, pin0 low
    do_write(0, 8'h06, "R9");
    do_write(0, 8'h07, "R9");
    @(negedge clk);
    pin_i[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 edge after two edges", {7'd0, req_o[0]}, 8'd0);
    @(negedge clk);
    chk("R9 edge after three edges", {7'd0, req_o[0]}, 8'd1);
    m_pend[0] = 1'b1;
    settle();
    do_clear(0, "R9");
    do_write(1, 8'h02, "R9");  // ch1 high level, disabled
    do_write(1, 8'h03, "R9");
    @(negedge clk);
    pin_i[1] = 1'b0;
    @(negedge clk);
    chk("R9 level after one edge", {7'd0, req_o[1]}, 8'd1);
    @(negedge clk);
    chk("R9 level after two edges", {7'd0, req_o[1]}, 8'd0);
    settle();

    // R2 falling edge latch on ch1
    do_write(1, 8'h04, "R2");
    do_write(1, 8'h05, "R2");
    drive_pin(1, 1'b1, "R2 rise no effect");
    drive_pin(1, 1'b0, "R2 fall latch");
    drive_pin(1, 1'b1, "R2 hold");
    do_clear(1, "R2 clear");
    do_clear(1, "R6 second clear");

    // R4 both-edges status on ch0 (pin0 high)
    do_write(0, 8'h08, "R4");
    do_write(0, 8'h09, "R4");
    drive_pin(0, 1'b0, "R4 fall 10");
    drive_pin(0, 1'b1, "R4 both 11");
    do_clear(0, "R6 clear status");
    drive_pin(0, 1'b0, "R4 fall");
    do_clear(0, "R6");
    drive_pin(0, 1'b1, "R4 rise 01");

    // R5 disabled in both-edges mode keeps status
    do_write(0, 8'h08, "R5 disable");
    drive_pin(0, 1'b0, "R5 no record");
    drive_pin(0, 1'b1, "R5 no request");

    // R3 reserved codes on ch1
    do_write(1, 8'h0A, "R3");
    do_write(1, 8'h0B, "R3");
    drive_pin(1, 1'b0, "R3 fall");
    drive_pin(1, 1'b1, "R3 rise");
    do_write(1, 8'h0F, "R3 code7");
    drive_pin(1, 1'b0, "R3 code7 fall");

    // R7 combined write
    do_write(1, 8'h06, "R7 mode change drops enable");
    do_write(1, 8'h05, "R7 combined write ignored enable");
    drive_pin(1, 1'b1, "R7");
    drive_pin(1, 1'b0, "R7 no request");
    do_write(1, 8'h05, "R7 enable later");
    drive_pin(1, 1'b1, "R7");
    drive_pin(1, 1'b0, "R7 request");
    do_write(1, 8'h09, "R7 mode change clears pending");

    // R8 junk upper bits
    do_write(0, 8'hF9, "R8 upper ignored");
    drive_pin(0, 1'b0, "R8");
    do_write(0, 8'hC9, "R8 status not writable");

    // random mix
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 300; k++) begin
      int c, op;
      c  = int'($urandom_range(0, NCH - 1));
      op = int'($urandom_range(0, 3));
      case (op)
        0: do_write(c, 8'($urandom_range(0, 255)), "RND write");
        1: do_clear(c, "RND clear");
        default: drive_pin(c, !pin_i[c], "RND pin");
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule